// File: doc/BRIEF.md
# Differential Manchester Serial Port

This block is a five-pin serial port that moves bytes between a parallel valid/ready stream and a single serial line. One pin, CP0, is always the receive input. The other four, CP1 to CP4, take different roles depending on a two-bit mode input. Two of the modes carry the line in Differential Manchester code. The first is a single-ended line with a transceiver enable. The second is a complementary driver pair that releases the pins while the port is idle. In the third mode the coding is left to an external transceiver. The port then sends raw bits, together with a bit clock and a frame clock that it generates, and it captures CP0 on that same bit clock.

Every bit cell lasts `8*(div+1)` system clocks. The transmitter always starts from a cleanly aligned cell when it accepts a byte. The receiver works from an already digitised CP0 level. It times each transition in eighth-of-a-cell ticks and realigns its tick counter on every cell-boundary transition. When a boundary transition is missing or comes at the wrong time, it pulses an error and discards the byte in progress. Bytes are sent least significant bit first.

Top module: `dm_serial_port`

## Requirements
- R1: The mode codes are 0 (single-ended), 1 (differential), 2 (special-purpose) and 3 (reserved). Output enables `cp_oe` use bit 0 for CP1, bit 1 for CP2, bit 2 for CP3 and bit 3 for CP4. The driven pins per mode are: single-ended CP1 and CP2; differential CP2 and CP3; special-purpose CP1, CP2 and CP4. In the reserved mode no pin is driven.
- R2: In the two coded modes, the transmit line (CP1 single-ended, CP2 differential) toggles at the start of every bit cell. It toggles once more at mid-cell for a 0 bit. A byte therefore produces 8 plus (number of zero bits) transitions. Each cell is `8*(div+1)` clocks long.
- R3: In single-ended mode, the transceiver enable on CP2 rises on the clock edge that accepts a byte. It stays high for exactly `64*(div+1)` clocks.
- R4: `tx_ready` is high only while the transmitter is idle. A byte is taken on a clock edge with `tx_valid` and `tx_ready` both high.
- R5: A correctly coded byte on CP0 in a coded mode appears on `rx_data` with `rx_valid` set. `rx_valid` holds until `rx_ready` is seen. A newer byte overwrites an unread one.
- R6: A transition on CP0 that is out of place, or a cell boundary missing for 10 ticks, raises `rx_err` for one clock. The partial byte is dropped and `rx_valid` is not set.
- R7: In differential mode, CP3 always carries the complement of CP2. Both pins are released (enable low) whenever no byte is being sent.
- R8: In special-purpose mode, CP1 carries each raw bit for a whole cell. CP2 is low in the first half of each cell and high in the second half, giving 8 rising edges per byte. CP4 is high for exactly the first cell of each byte.
- R9: In special-purpose mode, CP0 is sampled at each rising edge of the bit clock. The eight samples form `rx_data` at the end of the byte.
- R10: After reset the port is idle: `tx_ready` high, `rx_valid` and `rx_err` low, the transmit line low and the enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Pin configuration code (R1) |
| div | input | DIV_W | Clocks per tick minus one; a cell is 8 ticks |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_err | output | 1 | One-clock code violation pulse |
| cp0_in | input | 1 | Digitised receive level on CP0 |
| cp_drv | output | 4 | Drive values for CP1 (bit 0) to CP4 (bit 3) |
| cp_oe | output | 4 | Output enables for CP1 to CP4 |

## Verification
The case that is hardest to reach from the ports is a code violation. The transmitter only ever produces well-formed cells, so a loopback from the transmit pin to CP0 can never present a missing or misplaced boundary. To reach it, the bench cuts the loopback and drives CP0 itself. In one case it makes a single transition and then holds the level, so the boundary timeout expires. In the other it makes two transitions one clock apart. In both cases it watches for a single error pulse and checks that no byte is delivered.

// File: rtl/dm_port_pkg.sv
// Package: shared types and constants for the serial port.
// Assumes a bit cell of eight ticks and half-cell events at tick four.
package dm_port_pkg;
    typedef enum logic [1:0] {
        PM_SINGLE  = 2'd0,
        PM_DIFF    = 2'd1,
        PM_SPECIAL = 2'd2,
        PM_OFF     = 2'd3
    } port_mode_e;

    localparam int unsigned TICKS_PER_CELL = 8;
    localparam int unsigned PH_W           = 3;
    localparam int unsigned RUN_W          = 4;
endpackage

// File: rtl/dm_tick_gen.sv
// Module: tick prescaler. Emits one tick every div+1 clocks.
// Assumes clr restarts the count so the next tick comes div+1 clocks later.
module dm_tick_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div) && !clr;

    // Count clocks between ticks, restarting on clear or tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (clr || tick) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dm_tx.sv
// Module: transmit engine. Serialises one byte LSB first in eight-tick cells.
// In coded modes it keeps a Differential Manchester line level; in the
// special mode it exposes the raw bit, bit clock and frame clock instead.
// Assumes mode is held steady while a byte is in flight.
module dm_tx
    import dm_port_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_mode_e        mode,
    input  logic [DIV_W-1:0]  div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              busy,
    output logic              line,
    output logic              raw_bit,
    output logic              bclk,
    output logic              fclk,
    output logic              mid_stb,
    output logic              done_stb
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [PH_W-1:0]   ph;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              tick;
    logic              accept;
    logic              coded;
    logic              cell_end;

    assign tx_ready = !busy;
    assign accept   = tx_valid && !busy;
    assign coded    = (mode == PM_SINGLE) || (mode == PM_DIFF);
    assign cell_end = busy && tick && (ph == PH_W'(TICKS_PER_CELL - 1));
    assign mid_stb  = busy && tick && (ph == PH_W'(TICKS_PER_CELL/2 - 1));
    assign done_stb = cell_end && (idx == LAST_IDX);
    assign raw_bit  = busy ? sh[0] : 1'b1;
    assign bclk     = busy && ph[PH_W-1];
    assign fclk     = busy && (idx == '0);

    dm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(accept), .div(div), .tick(tick)
    );

    // Walk phase and bit index, shift data, and toggle the coded line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ph   <= '0;
            idx  <= '0;
            sh   <= '0;
            line <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
            ph   <= '0;
            idx  <= '0;
            sh   <= tx_data;
            if (coded) line <= ~line;
        end else if (busy && tick) begin
            ph <= ph + 1'b1;
            if (mid_stb && !sh[0] && coded) line <= ~line;
            if (cell_end) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                    sh  <= sh >> 1;
                    if (coded) line <= ~line;
                end
            end
        end
    end

    // R4: a taken byte closes the ready window on the next clock.
    p_take_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R2: between ticks the coded line never moves while sending.
    p_line_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(line));

    // R8: the frame clock starts in the low half of the bit clock.
    p_frame_low_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fclk) |-> !bclk);

    // R4: the last cell edge returns the transmitter to idle.
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> tx_ready);
endmodule

// File: rtl/dm_rx.sv
// Module: receive engine. In coded modes it times CP0 transitions in ticks,
// realigning on each cell boundary, and decodes Differential Manchester bits.
// In the special mode it shifts CP0 in on the transmit engine's bit clock.
// Assumes CP0 is already a clean digital level.
module dm_rx
    import dm_port_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_mode_e        mode,
    input  logic [DIV_W-1:0]  div,
    input  logic              cp0,
    input  logic              spc_sample,
    input  logic              spc_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_err
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic              rx_q, rx_p;
    logic              active, decided;
    logic [RUN_W-1:0]  run;
    logic [IDX_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic              coded, edge_seen, tick, clr;
    logic              mid_ok, bnd_ok;

    assign coded     = (mode == PM_SINGLE) || (mode == PM_DIFF);
    assign edge_seen = coded && (rx_q ^ rx_p);
    assign mid_ok    = !decided && (run >= RUN_W'(3)) && (run <= RUN_W'(5));
    assign bnd_ok    = decided && (run >= RUN_W'(7)) && (run <= RUN_W'(9));
    assign clr       = edge_seen && (!active || decided);

    dm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(clr), .div(div), .tick(tick)
    );

    // Register the input level and keep the previous one for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
            rx_p <= 1'b0;
        end else begin
            rx_q <= cp0;
            rx_p <= rx_q;
        end
    end

    // Decode cells, deliver bytes and flag code violations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            decided  <= 1'b0;
            run      <= '0;
            cnt      <= '0;
            sh       <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
        end else begin
            rx_err <= 1'b0;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (!coded) begin
                active <= 1'b0;
                if (spc_sample) sh <= {rx_q, sh[DATA_W-1:1]};
                if (spc_done) begin
                    rx_data  <= sh;
                    rx_valid <= 1'b1;
                end
            end else if (!active) begin
                if (edge_seen) begin
                    active  <= 1'b1;
                    decided <= 1'b0;
                    run     <= '0;
                    cnt     <= '0;
                end
            end else if (edge_seen) begin
                if (mid_ok) begin
                    decided <= 1'b1;
                    run     <= run + RUN_W'(tick);
                    sh      <= {1'b0, sh[DATA_W-1:1]};
                    cnt     <= cnt + 1'b1;
                    if (cnt == LAST_IDX) begin
                        rx_data  <= {1'b0, sh[DATA_W-1:1]};
                        rx_valid <= 1'b1;
                        active   <= 1'b0;
                    end
                end else if (bnd_ok) begin
                    decided <= 1'b0;
                    run     <= '0;
                end else begin
                    rx_err <= 1'b1;
                    active <= 1'b0;
                end
            end else if (tick) begin
                run <= run + 1'b1;
                if (!decided && run == RUN_W'(5)) begin
                    decided <= 1'b1;
                    sh      <= {1'b1, sh[DATA_W-1:1]};
                    cnt     <= cnt + 1'b1;
                    if (cnt == LAST_IDX) begin
                        rx_data  <= {1'b1, sh[DATA_W-1:1]};
                        rx_valid <= 1'b1;
                        active   <= 1'b0;
                    end
                end else if (run == RUN_W'(9)) begin
                    rx_err <= 1'b1;
                    active <= 1'b0;
                end
            end
        end
    end

    // R5: an unread byte stays offered until the consumer is ready.
    p_hold_unread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);

    // R6: a violation is reported for a single clock only.
    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !rx_err);

    // R6: a violation never coincides with a fresh delivery.
    p_err_no_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> !$rose(rx_valid));
endmodule

// File: rtl/dm_serial_port.sv
// Module: top of the five-pin serial port. Routes the transmit and receive
// engines onto CP1..CP4 according to the mode code; CP0 is always input.
// Assumes mode changes only while both directions are idle.
module dm_serial_port
    import dm_port_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [DIV_W-1:0]  div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_err,
    input  logic              cp0_in,
    output logic [3:0]        cp_drv,
    output logic [3:0]        cp_oe
);
    port_mode_e pmode;
    logic busy, line, raw_bit, bclk, fclk, mid_stb, done_stb;

    assign pmode = port_mode_e'(mode);

    dm_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode(pmode), .div(div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .busy(busy), .line(line), .raw_bit(raw_bit), .bclk(bclk),
        .fclk(fclk), .mid_stb(mid_stb), .done_stb(done_stb)
    );

    dm_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode(pmode), .div(div), .cp0(cp0_in),
        .spc_sample(mid_stb), .spc_done(done_stb),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_err(rx_err)
    );

    // Assign pin roles per mode: {CP4, CP3, CP2, CP1}.
    always_comb begin
        unique case (pmode)
            PM_SINGLE: begin
                cp_drv = {1'b0, 1'b0, busy, line};
                cp_oe  = 4'b0011;
            end
            PM_DIFF: begin
                cp_drv = {1'b0, ~line, line, 1'b0};
                cp_oe  = {1'b0, busy, busy, 1'b0};
            end
            PM_SPECIAL: begin
                cp_drv = {fclk, 1'b0, bclk, raw_bit};
                cp_oe  = 4'b1011;
            end
            default: begin
                cp_drv = 4'b0000;
                cp_oe  = 4'b0000;
            end
        endcase
    end

    // R7: the differential pair is always complementary.
    p_pair_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == PM_DIFF) |-> (cp_drv[2] == ~cp_drv[1]));

    // R1: the reserved code never drives a pin.
    p_reserved_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == PM_OFF) |-> (cp_oe == 4'b0000));
endmodule

// File: tb/test_dm_serial_port.sv
module test_dm_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] div = 8'd1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       rx_err;
    logic       cp0_in;
    logic [3:0] cp_drv, cp_oe;
    logic       force_on = 1'b0;
    logic       force_val = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    // Loopback: coded line pin back to CP0, unless the bench drives CP0.
    assign cp0_in = force_on ? force_val : ((mode == 2'd1) ? cp_drv[1] : cp_drv[0]);

    dm_serial_port i_dm_serial_port (
        .clk(clk), .rst_n(rst_n), .mode(mode), .div(div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_err(rx_err), .cp0_in(cp0_in), .cp_drv(cp_drv), .cp_oe(cp_oe)
    );

    // {mode, byte, expected line transitions}
    localparam logic [17:0] VEC [0:6] = '{
        {2'd0, 8'hA5, 8'd12},
        {2'd0, 8'h00, 8'd16},
        {2'd0, 8'hFF, 8'd8},
        {2'd1, 8'h3C, 8'd12},
        {2'd1, 8'h81, 8'd14},
        {2'd2, 8'h5A, 8'd0},
        {2'd2, 8'hC3, 8'd0}
    };

    int edges, en_cyc, frame_cyc, bclk_rise, pair_bad, ready_after;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one byte and watch the pins for one byte time plus margin.
    task automatic send_watch(input logic [7:0] b);
        logic pin_prev, bclk_prev, pin;
        edges = 0; en_cyc = 0; frame_cyc = 0; bclk_rise = 0; pair_bad = 0;
        @(negedge clk);
        pin_prev  = (mode == 2'd1) ? cp_drv[1] : cp_drv[0];
        bclk_prev = cp_drv[1];
        tx_data = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        ready_after = tx_ready;
        for (int k = 0; k < 140; k++) begin
            pin = (mode == 2'd1) ? cp_drv[1] : cp_drv[0];
            if (pin != pin_prev) edges++;
            pin_prev = pin;
            if (mode == 2'd0 && cp_drv[1]) en_cyc++;
            if (mode == 2'd1 && cp_oe[1]) en_cyc++;
            if (mode == 2'd1 && cp_oe[1] && cp_drv[2] == cp_drv[1]) pair_bad++;
            if (mode == 2'd2 && cp_drv[3]) frame_cyc++;
            if (mode == 2'd2 && cp_drv[1] && !bclk_prev) bclk_rise++;
            bclk_prev = cp_drv[1];
            @(negedge clk);
        end
    endtask

    task automatic take_rx();
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int errs, vals;
        do_reset();
        // R10: idle after reset
        @(negedge clk);
        check(tx_ready == 1'b1, "R10 tx_ready", tx_ready, 1);
        check(rx_valid == 1'b0 && rx_err == 1'b0, "R10 rx idle", {rx_valid, rx_err}, 0);
        check(cp_drv[1:0] == 2'b00, "R10 line/enable low", cp_drv[1:0], 0);
        check(cp_oe == 4'b0011, "R1 single-ended enables", cp_oe, 3);

        for (int i = 0; i < 7; i++) begin
            mode = VEC[i][17:16];
            @(negedge clk);
            if (mode == 2'd1)
                check(cp_oe == 4'b0000, "R7 idle release", cp_oe, 0);
            if (mode == 2'd2)
                check(cp_oe == 4'b1011, "R1 special enables", cp_oe, 11);
            send_watch(VEC[i][15:8]);
            check(ready_after == 0, "R4 busy after take", ready_after, 0);
            check(rx_valid == 1'b1 && rx_data == VEC[i][15:8],
                  (mode == 2'd2) ? "R9 raw receive" : "R5 decoded byte",
                  rx_data, VEC[i][15:8]);
            if (mode != 2'd2)
                check(edges == int'(VEC[i][7:0]), "R2 transition count", edges, VEC[i][7:0]);
            if (mode == 2'd0)
                check(en_cyc == 128, "R3 enable length", en_cyc, 128);
            if (mode == 2'd1) begin
                check(en_cyc == 128, "R7 drive window", en_cyc, 128);
                check(pair_bad == 0, "R7 complement", pair_bad, 0);
            end
            if (mode == 2'd2) begin
                check(frame_cyc == 16, "R8 frame clock", frame_cyc, 16);
                check(bclk_rise == 8, "R8 bit clock edges", bclk_rise, 8);
            end
            check(tx_ready == 1'b1, "R4 ready again", tx_ready, 1);
            take_rx();
            check(rx_valid == 1'b0, "R5 consumed", rx_valid, 0);
        end

        // R1: reserved code drives nothing
        mode = 2'd3;
        @(negedge clk);
        check(cp_oe == 4'b0000, "R1 reserved", cp_oe, 0);

        // R5: unread byte is held, then overwritten by a newer one
        mode = 2'd0;
        do_reset();
        send_watch(8'h12);
        repeat (20) @(negedge clk);
        check(rx_valid == 1'b1 && rx_data == 8'h12, "R5 held", rx_data, 8'h12);
        send_watch(8'h34);
        check(rx_valid == 1'b1 && rx_data == 8'h34, "R5 overwrite", rx_data, 8'h34);
        take_rx();

        // R6: single transition then silence -> missing boundary
        force_on = 1'b1;
        force_val = 1'b0;
        do_reset();
        repeat (4) @(negedge clk);
        force_val = 1'b1;
        errs = 0; vals = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (rx_err) errs++;
            if (rx_valid) vals++;
        end
        check(errs == 1, "R6 missing boundary error", errs, 1);
        check(vals == 0, "R6 byte dropped", vals, 0);

        // R6: two transitions one clock apart -> misplaced edge
        force_val = 1'b0;
        @(negedge clk);
        force_val = 1'b1;
        errs = 0; vals = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (rx_err) errs++;
            if (rx_valid) vals++;
        end
        check(errs == 1, "R6 early edge error", errs, 1);
        check(vals == 0, "R6 no delivery", vals, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule